// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned 16-bit operands and a single incoming carry in pure combinational logic. The operands are split into four 4-bit slices. Each slice forms a generate bit (both operand bits set) and a propagate bit (operand bits differ) at every position. It resolves the carries inside the slice with flattened lookahead equations and forms its own slice-level generate and propagate. A second lookahead unit of the same shape then takes the four slice generate/propagate pairs and the incoming carry. It returns the carry into every slice and the final carry-out directly, so no carry ripples from one slice to the next.

The block-level generate and propagate are brought out as ports. A wider adder can place this block under a third lookahead level. The block has no clock, reset, storage or handshake. Its outputs are valid once the inputs have settled, in the same cycle the operands are applied. There is no stream interface, so back-pressure does not arise. Subtraction, overflow detection and signed meaning are left to the surrounding logic.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, taken as unsigned values.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned result of `op_a + op_b + carry_in`.
- R3: `blk_prop` is 1 exactly when every bit of `op_a` differs from the bit of `op_b` at the same position, i.e. `op_a ^ op_b` is all ones.
- R4: `blk_gen` is 1 exactly when `op_a + op_b` (without `carry_in`) is 65536 or more.
- R5: `carry_out` equals `blk_gen | (blk_prop & carry_in)` for every input.
- R6: `blk_gen` and `blk_prop` are never 1 together.
- R7: The block holds no state, and every output follows the present inputs in the same cycle, independent of earlier inputs.
- R8: With a full-length propagate chain (`op_a ^ op_b` all ones) and `carry_in` = 1, `sum_out` is 0 and `carry_out` is 1. With `carry_in` = 0, `sum_out` is 0xFFFF and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Block-level generate, for a higher lookahead level |
| blk_prop | output | 1 | Block-level propagate, for a higher lookahead level |

## Verification
Every result of this block is due zero cycles after its stimulus. The sum, the carry-out and the two block-level terms all settle in the cycle the operands are applied. The driver applies one operand set on each rising edge and queues the expected values computed from a 17-bit behavioural addition. The monitor compares the four outputs on the following falling edge, so each comparison falls half a period after the stimulus and before the next one. Because consecutive vectors differ at random, a correct match on each vector also shows that no earlier vector leaves a trace.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Default slicing: width of one lookahead slice and number of slices.
  parameter int CLA_GRP_W = 4;
  parameter int CLA_GRP_N = 4;
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic bit_a,
  input  logic bit_b,
  output logic bit_gen,
  output logic bit_prop
);
  // Generate: both bits set. Propagate: half-sum of the two bits.
  assign bit_gen  = bit_a & bit_b;
  assign bit_prop = bit_a ^ bit_b;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] gen_in,
  input  logic [W-1:0] prop_in,
  input  logic         cin,
  output logic [W:0]   carry,
  output logic         gen_out,
  output logic         prop_out
);
  assign carry[0] = cin;

  // Every carry is a flat sum of products. The source at position j
  // must pass through the propagate bits j+1 .. k-1.
  for (genvar k = 1; k <= W; k++) begin : g_pos
    logic [k:0] term;
    for (genvar j = 0; j < k; j++) begin : g_src
      localparam logic [W-1:0] SPAN = W'(((1 << k) - 1) & ~((1 << (j + 1)) - 1));
      assign term[j] = gen_in[j] & (&(prop_in | ~SPAN));
    end
    localparam logic [W-1:0] ALLP = W'((1 << k) - 1);
    assign term[k]  = cin & (&(prop_in | ~ALLP));
    assign carry[k] = |term;
  end

  // Slice-level terms do not depend on the incoming carry.
  logic [W-1:0] gg_term;
  for (genvar j = 0; j < W; j++) begin : g_grp
    localparam logic [W-1:0] SPAN = W'(((1 << W) - 1) & ~((1 << (j + 1)) - 1));
    assign gg_term[j] = gen_in[j] & (&(prop_in | ~SPAN));
  end
  assign gen_out  = |gg_term;
  assign prop_out = &prop_in;
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] grp_a,
  input  logic [W-1:0] grp_b,
  input  logic         grp_cin,
  output logic [W-1:0] grp_sum,
  output logic         grp_cout,
  output logic         grp_gen,
  output logic         grp_prop
);
  logic [W-1:0] g_bit;
  logic [W-1:0] p_bit;
  logic [W:0]   c_bit;

  for (genvar i = 0; i < W; i++) begin : g_cell
    cla_bit_cell u_cell (
      .bit_a   (grp_a[i]),
      .bit_b   (grp_b[i]),
      .bit_gen (g_bit[i]),
      .bit_prop(p_bit[i])
    );
  end

  cla_lookahead #(.W(W)) u_la (
    .gen_in  (g_bit),
    .prop_in (p_bit),
    .cin     (grp_cin),
    .carry   (c_bit),
    .gen_out (grp_gen),
    .prop_out(grp_prop)
  );

  assign grp_sum  = p_bit ^ c_bit[W-1:0];
  assign grp_cout = c_bit[W];
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int GRP_W = cla_pkg::CLA_GRP_W,
  parameter int GRP_N = cla_pkg::CLA_GRP_N,
  localparam int DW   = GRP_W * GRP_N
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          carry_in,
  output logic [DW-1:0] sum_out,
  output logic          carry_out,
  output logic          blk_gen,
  output logic          blk_prop
);
  logic [GRP_N-1:0] slice_gen;
  logic [GRP_N-1:0] slice_prop;
  logic [GRP_N-1:0] slice_cout;
  logic [GRP_N:0]   lvl2_c;

  for (genvar s = 0; s < GRP_N; s++) begin : g_slice
    cla_group #(.W(GRP_W)) u_grp (
      .grp_a   (op_a[s*GRP_W +: GRP_W]),
      .grp_b   (op_b[s*GRP_W +: GRP_W]),
      .grp_cin (lvl2_c[s]),
      .grp_sum (sum_out[s*GRP_W +: GRP_W]),
      .grp_cout(slice_cout[s]),
      .grp_gen (slice_gen[s]),
      .grp_prop(slice_prop[s])
    );
  end

  // Second lookahead level over the slice generate/propagate pairs.
  cla_lookahead #(.W(GRP_N)) u_lvl2 (
    .gen_in  (slice_gen),
    .prop_in (slice_prop),
    .cin     (carry_in),
    .carry   (lvl2_c),
    .gen_out (blk_gen),
    .prop_out(blk_prop)
  );

  assign carry_out = lvl2_c[GRP_N];
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int GRP_W = 4,
  parameter int GRP_N = 4,
  localparam int DW   = GRP_W * GRP_N
) (
  input logic [DW-1:0]    op_a,
  input logic [DW-1:0]    op_b,
  input logic             carry_in,
  input logic [DW-1:0]    sum_out,
  input logic             carry_out,
  input logic             blk_gen,
  input logic             blk_prop,
  input logic [GRP_N-1:0] slice_cout,
  input logic [GRP_N:0]   lvl2_c
);
  logic [DW:0] ref_full;
  logic [DW:0] ref_nocin;
  assign ref_full  = {1'b0, op_a} + {1'b0, op_b} + {{DW{1'b0}}, carry_in};
  assign ref_nocin = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    AST_SUM_VALUE: assert (sum_out == ref_full[DW-1:0]) else $error("sum mismatch"); // R1
    AST_CARRY_OUT: assert (carry_out == ref_full[DW]) else $error("carry mismatch"); // R2
    AST_PROP_ALL: assert (blk_prop == (&(op_a ^ op_b))) else $error("propagate mismatch"); // R3
    AST_GEN_NOCIN: assert (blk_gen == ref_nocin[DW]) else $error("generate mismatch"); // R4
    AST_CARRY_GP: assert (carry_out == (blk_gen | (blk_prop & carry_in))) else $error("carry vs G/P"); // R5
    AST_GP_EXCL: assert (!(blk_gen && blk_prop)) else $error("G and P both set"); // R6
    AST_CHAIN_END: assert (!((&(op_a ^ op_b)) && carry_in) || (sum_out == '0 && carry_out)) else $error("chain wrap"); // R8
    AST_LVL2_BASE: assert (lvl2_c[0] == carry_in) else $error("level-2 carry base"); // R1
  end

  // Carry formed inside each slice must agree with the second-level carry.
  for (genvar s = 0; s < GRP_N; s++) begin : g_x
    always_comb begin
      AST_SLICE_CARRY: assert (slice_cout[s] == lvl2_c[s+1]) else $error("slice carry disagree"); // R2
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.GRP_W(GRP_W), .GRP_N(GRP_N)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .carry_out (carry_out),
  .blk_gen   (blk_gen),
  .blk_prop  (blk_prop),
  .slice_cout(slice_cout),
  .lvl2_c    (lvl2_c)
);

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic          carry_in = 1'b0;
  logic [DW-1:0] sum_out;
  logic          carry_out;
  logic          blk_gen;
  logic          blk_prop;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic          ci;
    string         req;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk; // 125 MHz

  cla16_adder uut (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out),
    .blk_gen  (blk_gen),
    .blk_prop (blk_prop)
  );

  // Driver: one vector per rising edge, expectation queued alongside.
  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic ci, input string req);
    item_t it;
    @(posedge clk);
    op_a = a;
    op_b = b;
    carry_in = ci;
    it.a = a; it.b = b; it.ci = ci; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW:0] act, input logic [DW:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: results are due in the same cycle (R7), sampled on the falling edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [DW:0] full;
      logic [DW:0] nocin;
      logic        exp_p;
      it    = sb_q.pop_front();
      full  = {1'b0, it.a} + {1'b0, it.b} + {{DW{1'b0}}, it.ci};
      nocin = {1'b0, it.a} + {1'b0, it.b};
      exp_p = &(it.a ^ it.b);
      check(sum_out == full[DW-1:0], {"R1 ", it.req}, "sum", {1'b0, sum_out}, {1'b0, full[DW-1:0]});
      check(carry_out == full[DW], {"R2 ", it.req}, "cout", {{DW{1'b0}}, carry_out}, {{DW{1'b0}}, full[DW]});
      check(blk_prop == exp_p, {"R3 ", it.req}, "prop", {{DW{1'b0}}, blk_prop}, {{DW{1'b0}}, exp_p});
      check(blk_gen == nocin[DW], {"R4 ", it.req}, "gen", {{DW{1'b0}}, blk_gen}, {{DW{1'b0}}, nocin[DW]});
      check(carry_out == (blk_gen | (blk_prop & it.ci)), {"R5 ", it.req}, "cout_vs_gp",
            {{DW{1'b0}}, carry_out}, {{DW{1'b0}}, blk_gen | (blk_prop & it.ci)});
      check(!(blk_gen && blk_prop), {"R6 ", it.req}, "gp_excl",
            {{DW{1'b0}}, blk_gen & blk_prop}, '0);
    end
  end

  initial begin
    // Idle inputs: all zero, no carry.
    drive(16'h0000, 16'h0000, 1'b0, "R7_zero");
    drive(16'h0000, 16'h0000, 1'b1, "R7_zero_cin");
    drive(16'hFFFF, 16'h0001, 1'b0, "R2_ones_plus_one");
    drive(16'hFFFF, 16'h0000, 1'b1, "R8_ones_cin");
    drive(16'hFFFF, 16'h0000, 1'b0, "R8_ones_nocin");
    drive(16'hAAAA, 16'h5555, 1'b1, "R8_alt_cin");
    drive(16'hAAAA, 16'h5555, 1'b0, "R8_alt_nocin");
    drive(16'hAAAA, 16'hAAAA, 1'b0, "R4_alt_gen");
    drive(16'h5555, 16'h5555, 1'b1, "R1_alt_same");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R6_max");
    drive(16'h8000, 16'h8000, 1'b0, "R4_top_gen");
    drive(16'h0FFF, 16'h0001, 1'b0, "R1_three_slices");
    drive(16'h00FF, 16'hFF00, 1'b1, "R8_slice_split");
    drive(16'h7FFF, 16'h8000, 1'b1, "R8_half_split");
    for (int s = 0; s < 4; s++) begin
      // Carry born in slice s, propagated through all slices above it.
      drive(16'hFFFF << (4*s), 16'h0001 << (4*s), 1'b0, "R5_slice_gen");
    end
    for (int i = 0; i < 2000; i++) begin
      logic [DW-1:0] ra;
      logic [DW-1:0] rb;
      ra = DW'($urandom);
      rb = (i % 4 == 0) ? ~ra : DW'($urandom);
      drive(ra, rb, 1'($urandom), "R7_random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule